// File: doc/BRIEF.md
# Multi-rate sample bit interleaver

This block turns a stream of channel samples into 16-bit memory words. The packing depends on the sample-rate mode. At base rate each 16-channel sample becomes one word as it is. At double rate, two consecutive samples of 8 channels fill one word. At quad rate, four consecutive samples of 4 channels fill one word. The word then covers one 20 ns period, with the samples 5 ns apart.

The samples that share a word are interleaved bit by bit, channel-major. Word bit `ch*N + k` holds channel `ch` of the `k`-th sample in the group, where N is the packing factor (2 or 4). A host that reads the word can therefore pull out one channel as N adjacent bits.

The upstream capture logic presents one sample per cycle with a valid flag and a mode select. Memory-write logic takes each finished word when the valid strobe pulses. Unpacking on the host side is outside this block.

Top module: `rate_interleaver`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, `word_valid_o` is 0 and `word_o` is 0.
- R2: In base mode (`mode_i` = 0), every accepted sample appears unchanged on `word_o`, with `word_valid_o` high, in the cycle after it is accepted.
- R3: In double mode (`mode_i` = 1), every second accepted sample completes a word. Word bit `ch*2+k` (ch 0..7, k 0..1) holds `smp_i[ch]` of the k-th sample in the group. The word appears one cycle after the second sample.
- R4: In quad mode (`mode_i` = 2), every fourth accepted sample completes a word. Word bit `ch*4+k` (ch 0..3, k 0..3) holds `smp_i[ch]` of the k-th sample in the group. The word appears one cycle after the fourth sample.
- R5: Sample bits above the channel count of the active mode are ignored: bits 15:8 in double mode and bits 15:4 in quad mode have no effect on `word_o`.
- R6: Cycles with `smp_valid_i` low neither advance the group position nor raise `word_valid_o` in the following cycle.
- R7: A change of `mode_i` from its value in the previous cycle drops any partly filled group. A sample accepted in that same cycle counts as the first sample of a new group under the new mode.
- R8: Mode code 3 behaves exactly like base mode.
- R9: `word_o` holds its value in every cycle in which `word_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Rate mode: 0 base, 1 double, 2 quad, 3 base |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_i | input | 16 | Channel sample, bit n = channel n |
| word_o | output | 16 | Packed memory word |
| word_valid_o | output | 1 | One-cycle strobe: a new word is on `word_o` |

## Verification
The bench builds the block with its default 16-bit word width, the only width the memory format uses. At that width it reaches every packing factor the mode select offers: 16 channels at factor 1, 8 channels at factor 2 and 4 channels at factor 4. It also reaches the reserved mode code. The stimulus drives gaps in the valid flag, mode switches in the middle of a group, and junk in the unused upper channels. A long random run mixes all modes, so group boundaries land on every phase of each mode.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    MODE_BASE = 2'd0,
    MODE_X2   = 2'd1,
    MODE_X4   = 2'd2,
    MODE_RSVD = 2'd3
  } rate_mode_e;

  // index of the last sample in a word group
  function automatic logic [1:0] last_phase(rate_mode_e m);
    case (m)
      MODE_X2: last_phase = 2'd1;
      MODE_X4: last_phase = 2'd3;
      default: last_phase = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/ilv_phase_ctr.sv
module ilv_phase_ctr
  import ilv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  rate_mode_e mode_i,
  input  logic       smp_valid_i,
  output logic [1:0] phase_o,
  output logic       word_done_o
);

  rate_mode_e mode_q;
  logic [1:0] phase_q, phase_d, last;
  logic       mode_chg;

  assign mode_chg    = (mode_i != mode_q);
  assign last        = last_phase(mode_i);
  assign phase_o     = mode_chg ? 2'd0 : phase_q;
  assign word_done_o = smp_valid_i && (phase_o == last);

  always_comb begin
    phase_d = phase_o;
    if (smp_valid_i) phase_d = (phase_o == last) ? 2'd0 : phase_o + 2'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_BASE;
      phase_q <= 2'd0;
    end else begin
      mode_q  <= mode_i;
      phase_q <= phase_d;
    end
  end

  // R7
  mode_chg_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_chg && !smp_valid_i) |=> (phase_q == 2'd0));

  // R3 R4
  phase_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= last_phase(mode_q));

endmodule

// File: rtl/ilv_lane_merge.sv
module ilv_lane_merge
  import ilv_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  rate_mode_e        mode_i,
  input  logic [1:0]        phase_i,
  input  logic [WORD_W-1:0] smp_i,
  input  logic [WORD_W-1:0] acc_i,
  output logic [WORD_W-1:0] merged_o
);

  localparam int CH_X2 = WORD_W / 2;
  localparam int CH_X4 = WORD_W / 4;

  logic [WORD_W-1:0] m_x2, m_x4;

  // channel-major interleave: bit ch*N+k <- channel ch of sample k
  for (genvar ch = 0; ch < CH_X2; ch++) begin : g_x2_ch
    for (genvar k = 0; k < 2; k++) begin : g_x2_k
      assign m_x2[ch*2+k] = (phase_i == 2'(k)) ? smp_i[ch] : acc_i[ch*2+k];
    end
  end

  for (genvar ch = 0; ch < CH_X4; ch++) begin : g_x4_ch
    for (genvar k = 0; k < 4; k++) begin : g_x4_k
      assign m_x4[ch*4+k] = (phase_i == 2'(k)) ? smp_i[ch] : acc_i[ch*4+k];
    end
  end

  always_comb begin
    case (mode_i)
      MODE_X2: merged_o = m_x2;
      MODE_X4: merged_o = m_x4;
      default: merged_o = smp_i;
    endcase
  end

endmodule

// File: rtl/ilv_word_reg.sv
module ilv_word_reg #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic              word_done_i,
  input  logic [WORD_W-1:0] merged_i,
  output logic [WORD_W-1:0] acc_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o        <= '0;
      word_o       <= '0;
      word_valid_o <= 1'b0;
    end else begin
      word_valid_o <= word_done_i;
      if (smp_valid_i) acc_o <= merged_i;
      if (word_done_i) word_o <= merged_i;
    end
  end

  // R6
  idle_no_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> !word_valid_o);

  // R9
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_o |-> $stable(word_o));

endmodule

// File: rtl/rate_interleaver.sv
module rate_interleaver
  import ilv_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              smp_valid_i,
  input  logic [WORD_W-1:0] smp_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);

  rate_mode_e        mode;
  logic [1:0]        phase;
  logic              word_done;
  logic [WORD_W-1:0] acc, merged;

  assign mode = rate_mode_e'(mode_i);

  ilv_phase_ctr u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .smp_valid_i (smp_valid_i),
    .phase_o     (phase),
    .word_done_o (word_done)
  );

  ilv_lane_merge #(.WORD_W(WORD_W)) u_merge (
    .mode_i   (mode),
    .phase_i  (phase),
    .smp_i    (smp_i),
    .acc_i    (acc),
    .merged_o (merged)
  );

  ilv_word_reg #(.WORD_W(WORD_W)) u_word (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .smp_valid_i  (smp_valid_i),
    .word_done_i  (word_done),
    .merged_i     (merged),
    .acc_o        (acc),
    .word_o       (word_o),
    .word_valid_o (word_valid_o)
  );

  // R2 R8
  base_every_smp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && (mode_i == 2'd0 || mode_i == 2'd3)) |=> word_valid_o);

  // R2
  base_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && mode_i == 2'd0) |=> (word_o == $past(smp_i)));

endmodule

// File: tb/rate_interleaver_tb_top.sv
module rate_interleaver_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        vld = 1'b0;
  logic [15:0] smp = '0;
  logic [15:0] word;
  logic        word_vld;

  always #10 clk = ~clk;

  rate_interleaver dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .smp_valid_i(vld),
    .smp_i(smp), .word_o(word), .word_valid_o(word_vld)
  );

  int checks = 0, fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  // reference model state
  logic [1:0]  m_mode = 2'd0;
  int          m_phase = 0;
  logic [15:0] m_acc = '0;
  string       cur_tag = "R2";

  function automatic int fac(logic [1:0] md);
    return (md == 2'd1) ? 2 : (md == 2'd2) ? 4 : 1;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected word pushed when a group fills
  task automatic drive(logic [1:0] md, logic v, logic [15:0] d);
    int n;
    @(negedge clk);
    mode = md; vld = v; smp = d;
    if (md != m_mode) begin m_mode = md; m_phase = 0; end
    if (v) begin
      n = fac(md);
      for (int ch = 0; ch < 16 / n; ch++) m_acc[ch*n + m_phase] = d[ch];
      if (m_phase == n - 1) begin
        exp_q.push_back(m_acc);
        tag_q.push_back(cur_tag);
        m_phase = 0;
      end else m_phase++;
    end
  endtask

  // monitor
  logic [15:0] last_word = '0;
  logic        mon_on = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (word_vld) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R6 actual=unexpected word %h expected=no word", word);
        end else begin
          string t;
          logic [15:0] e;
          t = tag_q.pop_front();
          e = exp_q.pop_front();
          check(t, word, e);
        end
        last_word = word;
      end else begin
        check("R9", word, last_word);
      end
    end
  end

  initial begin
    bit done = 0;
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          checks++; fails++;
          $display("FAIL watchdog actual=timeout expected=finish");
          $display("%0d/%0d checks passed", checks - fails, checks);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    check("R1", word, 16'h0);
    check("R1", {15'b0, word_vld}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {15'b0, word_vld}, 16'h0);
    mon_on = 1'b1;

    cur_tag = "R2";
    drive(2'd0, 1, 16'hA5C3);
    drive(2'd0, 1, 16'h0001);
    drive(2'd0, 0, 16'hFFFF);
    drive(2'd0, 1, 16'h8000);

    cur_tag = "R3";
    drive(2'd1, 1, 16'h00FF);
    drive(2'd1, 1, 16'h0000);
    drive(2'd1, 1, 16'h0055);
    drive(2'd1, 1, 16'h00AA);

    cur_tag = "R6";
    drive(2'd1, 1, 16'h0012);
    drive(2'd1, 0, 16'h00FF);
    drive(2'd1, 0, 16'h00FF);
    drive(2'd1, 1, 16'h0034);

    cur_tag = "R4";
    drive(2'd2, 1, 16'h0001);
    drive(2'd2, 1, 16'h0002);
    drive(2'd2, 1, 16'h0004);
    drive(2'd2, 1, 16'h0008);
    drive(2'd2, 1, 16'h000F);
    drive(2'd2, 0, 16'h0000);
    drive(2'd2, 1, 16'h0000);
    drive(2'd2, 1, 16'h000F);
    drive(2'd2, 1, 16'h0005);

    cur_tag = "R5";
    drive(2'd1, 1, 16'hFF3C);
    drive(2'd1, 1, 16'h5AC3);
    drive(2'd2, 1, 16'hFFF9);
    drive(2'd2, 1, 16'hABC6);
    drive(2'd2, 1, 16'h1230);
    drive(2'd2, 1, 16'hEEEF);

    cur_tag = "R7";
    drive(2'd2, 1, 16'h000F);
    drive(2'd2, 1, 16'h000F);
    drive(2'd1, 1, 16'h0081);
    drive(2'd1, 1, 16'h0042);
    drive(2'd2, 1, 16'h0003);
    drive(2'd0, 0, 16'h0000);
    drive(2'd0, 1, 16'h1357);

    cur_tag = "R8";
    drive(2'd3, 1, 16'hBEEF);
    drive(2'd3, 1, 16'h0F0F);
    drive(2'd3, 0, 16'h0000);

    cur_tag = "R3 R4 R7";
    for (int i = 0; i < 400; i++) begin
      logic [1:0] md;
      md = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(0, 3)) : m_mode;
      drive(md, 1'($urandom_range(0, 3) != 0), 16'($urandom));
    end

    drive(m_mode, 0, 16'h0);
    drive(m_mode, 0, 16'h0);
    check("R6", 16'(exp_q.size()), 16'h0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule